// File: doc/BRIEF.md
# Descriptor-Chain Scatter-Gather DMA Engine

This block is a bus master that moves data between system memory and a card-side data stream by walking a chain of 8-byte descriptors held in memory. Software writes the address of the first descriptor into the table-address register while the DMA enable input is high. The engine then reads each descriptor in turn and acts on its attribute byte. It can move a block of words, skip the entry, jump to another table, or stop. It never needs software between segments of a scattered buffer.

Data flows in one of two directions, chosen by an input sampled when the chain starts. In the memory-to-card direction the engine reads words and offers them on a valid/ready transmit stream. In the card-to-memory direction it accepts words from a valid/ready receive stream and writes them to memory. On completion it sets a done flag. On a fault it halts and records a 2-bit code for the phase that failed. The table-address register then holds either the faulty descriptor or the one after it, depending on that phase. Flags raise the interrupt output only through a per-bit enable mask.

Top module: `sg_desc_dma`

## Requirements
- R1: After reset the interrupt status, interrupt enable and error code registers read zero, `irq` is low, and neither `memReq` nor `txValid` is asserted.
- R2: A register write to offset 0 (table address) while the engine is stopped loads the address. It starts descriptor fetching only if `dmaEn` is high. The first memory reads are the word at that address and then the word at address+4.
- R3: A descriptor is two little-endian words. In word 0, bits 7:0 are the attributes (bit 0 valid, bit 1 end, bit 2 interrupt, bits 5:4 action) and bits 31:16 are the byte length. Word 1 is the buffer or link address.
- R4: Action 2'b10 moves length/4 words. The addresses start at the address field and step by 4. In memory-to-card mode each word read appears in order on `txData`. In card-to-memory mode each word taken from `rxData` is written in order.
- R5: Action 2'b11 without the end bit makes the next fetch start at the address field. Action 2'b00 is a no-op: the engine moves on to the next descriptor.
- R6: After the engine processes a descriptor with the end bit, it sets interrupt status bit 1 (done) and stops. The table-address register then points 8 bytes past that descriptor.
- R7: A transfer descriptor whose length field is zero moves 65536 bytes (16384 words).
- R8: A fetch-phase fault stores error code 1, and the table-address register keeps the faulty descriptor's address. Fetch-phase faults are: valid bit clear, a memory error response while reading the descriptor, or a descriptor address that is not 8-byte aligned.
- R9: A transfer-phase fault stores error code 3, and the table-address register points to the next descriptor. Transfer-phase faults are: a length that is not a multiple of 4, a buffer address that is not word aligned, or a memory error response during the data phase.
- R10: The reserved action 2'b01 is a stop-phase fault. It stores error code 0, and the table-address register points to the next descriptor.
- R11: Any fault sets interrupt status bit 25 and halts the engine. `irq` is high only while a status bit and its enable bit (offset 2) are both set. Writing 1s to offset 1 clears those status bits.
- R12: A descriptor with the interrupt attribute sets status bit 3 once its data has been moved. A descriptor without that attribute leaves bit 3 clear.
- R13: The direction is sampled from `dirToMem` at start. Changing that input during a chain does not change the direction.
- R14: A `softRst` pulse returns the engine to the stopped state. Memory requests and stream activity cease, and a new chain can then be started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dmaEn | input | 1 | Allows a table-address write to start a chain |
| dirToMem | input | 1 | 1: card-to-memory, 0: memory-to-card; sampled at start |
| softRst | input | 1 | Synchronous return to the stopped state |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 table address, 1 status, 2 enable, 3 error code |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| irq | output | 1 | Interrupt request |
| memReq | output | 1 | Memory access request, held until `memAck` |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Memory byte address |
| memWrData | output | 32 | Memory write data |
| memAck | input | 1 | Memory access complete |
| memErr | input | 1 | Error response, valid with `memAck` |
| memRdData | input | 32 | Memory read data, valid with `memAck` |
| txValid | output | 1 | Transmit stream word valid |
| txData | output | 32 | Transmit stream word |
| txReady | input | 1 | Transmit stream ready |
| rxValid | input | 1 | Receive stream word valid |
| rxData | input | 32 | Receive stream word |
| rxReady | output | 1 | Receive stream ready |

## Verification
The bench targets where the reported table address lands for each fault phase. A design that advanced the pointer before checking the valid bit would report the wrong descriptor for code 1. One that forgot to advance on a bad length would report the wrong descriptor for code 3. A zero-length descriptor is run end to end: an engine that read the zero literally would move nothing, and one that used too narrow a word counter would stop short of 16384 words. The bench also links through a table and a no-op entry, flips the direction input mid-chain, and pulses the soft reset during a long transfer. Broken pointer updates, a direction that is not latched, or requests that keep running after the reset are then visible at the ports.

// File: rtl/sg_dma_pkg.sv
package sg_dma_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 16;
  localparam int CNT_W  = LEN_W - 1;
  localparam int DESC_BYTES = 8;

  localparam logic [1:0] REG_TABLE  = 2'd0;
  localparam logic [1:0] REG_STATUS = 2'd1;
  localparam logic [1:0] REG_ENABLE = 2'd2;
  localparam logic [1:0] REG_ERR    = 2'd3;

  localparam int IRQ_DONE_BIT = 1;
  localparam int IRQ_DESC_BIT = 3;
  localparam int IRQ_ERR_BIT  = 25;

  localparam logic [1:0] PH_STOP  = 2'd0;
  localparam logic [1:0] PH_FETCH = 2'd1;
  localparam logic [1:0] PH_XFER  = 2'd3;

  localparam logic [1:0] ACT_NOP  = 2'b00;
  localparam logic [1:0] ACT_RSV  = 2'b01;
  localparam logic [1:0] ACT_MOVE = 2'b10;
  localparam logic [1:0] ACT_LINK = 2'b11;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH0, S_FETCH1, S_DECODE, S_RD, S_PUSH, S_POP, S_WR, S_FIN
  } engStateT;

  typedef enum logic [1:0] {SEL_DESC0, SEL_DESC1, SEL_DATA} addrSelT;

  typedef struct packed {
    logic       start;
    logic       loadW0;
    logic       loadW1;
    logic       advance;
    logic       link;
    logic       startXfer;
    logic       captureMem;
    logic       captureRx;
    logic       wordDone;
    logic       setDone;
    logic       setDescIrq;
    logic       setErr;
    logic [1:0] errCode;
    addrSelT    addrSel;
  } ctlT;

  typedef struct packed {
    logic       valid;
    logic       endFlag;
    logic       intFlag;
    logic [1:0] action;
    logic       lenBad;
    logic       addrBad;
    logic       lastWord;
    logic       descMisaligned;
    logic       dirToMem;
  } flagT;

endpackage

// File: rtl/sg_dma_datapath.sv
module sg_dma_datapath
  import sg_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirToMem,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  ctlT               ctl,
  input  logic              idle,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [DATA_W-1:0] rxData,
  output flagT              flags,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] txData,
  output logic              irq
);

  localparam logic [CNT_W-1:0] FULL_WORDS = CNT_W'(1) << (LEN_W - 2);

  logic [ADDR_W-1:0] descAddr;
  logic [ADDR_W-1:0] addrField;
  logic [ADDR_W-1:0] dataAddr;
  logic [LEN_W-1:0]  lenField;
  logic [5:0]        attrReg;
  logic [CNT_W-1:0]  wordsLeft;
  logic [DATA_W-1:0] dataBuf;
  logic [DATA_W-1:0] intStatus;
  logic [DATA_W-1:0] intEnable;
  logic [1:0]        errState;
  logic              dirLat;
  logic [DATA_W-1:0] setBits;

  // Descriptor pointer: software load, link jump or step past the entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descAddr <= '0;
    end else if (regWrEn && regAddr == REG_TABLE && idle) begin
      descAddr <= regWrData;
    end else if (ctl.link) begin
      descAddr <= addrField;
    end else if (ctl.advance) begin
      descAddr <= descAddr + ADDR_W'(DESC_BYTES);
    end
  end

  // Descriptor fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attrReg   <= '0;
      lenField  <= '0;
      addrField <= '0;
    end else begin
      if (ctl.loadW0) begin
        attrReg  <= memRdData[5:0];
        lenField <= memRdData[31:16];
      end
      if (ctl.loadW1) begin
        addrField <= memRdData;
      end
    end
  end

  // Data segment walker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataAddr  <= '0;
      wordsLeft <= '0;
      dataBuf   <= '0;
      dirLat    <= 1'b0;
    end else begin
      if (ctl.start) dirLat <= dirToMem;
      if (ctl.startXfer) begin
        dataAddr  <= addrField;
        wordsLeft <= (lenField == '0) ? FULL_WORDS
                                       : CNT_W'(lenField[LEN_W-1:2]);
      end else if (ctl.wordDone) begin
        dataAddr  <= dataAddr + ADDR_W'(4);
        wordsLeft <= wordsLeft - CNT_W'(1);
      end
      if (ctl.captureMem)     dataBuf <= memRdData;
      else if (ctl.captureRx) dataBuf <= rxData;
    end
  end

  // Interrupt status, enable and error code
  always_comb begin
    setBits = '0;
    setBits[IRQ_DONE_BIT] = ctl.setDone;
    setBits[IRQ_DESC_BIT] = ctl.setDescIrq;
    setBits[IRQ_ERR_BIT]  = ctl.setErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intStatus <= '0;
      intEnable <= '0;
      errState  <= PH_STOP;
    end else begin
      if (regWrEn && regAddr == REG_STATUS)
        intStatus <= (intStatus & ~regWrData) | setBits;
      else
        intStatus <= intStatus | setBits;
      if (regWrEn && regAddr == REG_ENABLE) intEnable <= regWrData;
      if (ctl.setErr) errState <= ctl.errCode;
    end
  end

  always_comb begin
    case (regAddr)
      REG_TABLE:  regRdData = descAddr;
      REG_STATUS: regRdData = intStatus;
      REG_ENABLE: regRdData = intEnable;
      default:    regRdData = {{(DATA_W-2){1'b0}}, errState};
    endcase
  end

  always_comb begin
    case (ctl.addrSel)
      SEL_DESC0: memAddr = descAddr;
      SEL_DESC1: memAddr = descAddr + ADDR_W'(4);
      default:   memAddr = dataAddr;
    endcase
  end

  assign memWrData = dataBuf;
  assign txData    = dataBuf;
  assign irq       = |(intStatus & intEnable);

  assign flags.valid          = attrReg[0];
  assign flags.endFlag        = attrReg[1];
  assign flags.intFlag        = attrReg[2];
  assign flags.action         = attrReg[5:4];
  assign flags.lenBad         = lenField[1:0] != 2'b00;
  assign flags.addrBad        = addrField[1:0] != 2'b00;
  assign flags.lastWord       = wordsLeft == CNT_W'(1);
  assign flags.descMisaligned = descAddr[2:0] != 3'b000;
  assign flags.dirToMem       = dirLat;

  assert_err_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setErr |=> intStatus[IRQ_ERR_BIT]);

  assert_fetch_err_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.setErr && ctl.errCode == PH_FETCH) |=> $stable(descAddr));

  assert_xfer_err_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.setErr && ctl.errCode == PH_XFER) |=> errState == PH_XFER);

endmodule

// File: rtl/sg_dma_ctrl.sv
module sg_dma_ctrl
  import sg_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       dmaEn,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  flagT       flags,
  input  logic       memAck,
  input  logic       memErr,
  input  logic       txReady,
  input  logic       rxValid,
  output ctlT        ctl,
  output logic       memReq,
  output logic       memWe,
  output logic       txValid,
  output logic       rxReady,
  output logic       idle
);

  engStateT state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= S_IDLE;
    else if (softRst) state <= S_IDLE;
    else              state <= nextState;
  end

  assign idle = state == S_IDLE;

  always_comb begin
    ctl       = '0;
    nextState = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    txValid   = 1'b0;
    rxReady   = 1'b0;
    case (state)
      S_IDLE: begin
        if (regWrEn && regAddr == REG_TABLE && dmaEn) begin
          ctl.start = 1'b1;
          nextState = S_FETCH0;
        end
      end
      S_FETCH0: begin
        ctl.addrSel = SEL_DESC0;
        if (flags.descMisaligned) begin
          ctl.setErr  = 1'b1;
          ctl.errCode = PH_FETCH;
          nextState   = S_IDLE;
        end else begin
          memReq = 1'b1;
          if (memAck && memErr) begin
            ctl.setErr  = 1'b1;
            ctl.errCode = PH_FETCH;
            nextState   = S_IDLE;
          end else if (memAck) begin
            ctl.loadW0 = 1'b1;
            nextState  = S_FETCH1;
          end
        end
      end
      S_FETCH1: begin
        ctl.addrSel = SEL_DESC1;
        memReq      = 1'b1;
        if (memAck && memErr) begin
          ctl.setErr  = 1'b1;
          ctl.errCode = PH_FETCH;
          nextState   = S_IDLE;
        end else if (memAck) begin
          ctl.loadW1 = 1'b1;
          nextState  = S_DECODE;
        end
      end
      S_DECODE: begin
        if (!flags.valid) begin
          ctl.setErr  = 1'b1;
          ctl.errCode = PH_FETCH;
          nextState   = S_IDLE;
        end else begin
          case (flags.action)
            ACT_RSV: begin
              ctl.advance = 1'b1;
              ctl.setErr  = 1'b1;
              ctl.errCode = PH_STOP;
              nextState   = S_IDLE;
            end
            ACT_NOP: begin
              ctl.advance = 1'b1;
              nextState   = flags.endFlag ? S_FIN : S_FETCH0;
            end
            ACT_LINK: begin
              if (flags.endFlag) begin
                ctl.advance = 1'b1;
                nextState   = S_FIN;
              end else begin
                ctl.link  = 1'b1;
                nextState = S_FETCH0;
              end
            end
            default: begin
              ctl.advance = 1'b1;
              if (flags.lenBad || flags.addrBad) begin
                ctl.setErr  = 1'b1;
                ctl.errCode = PH_XFER;
                nextState   = S_IDLE;
              end else begin
                ctl.startXfer = 1'b1;
                nextState     = flags.dirToMem ? S_POP : S_RD;
              end
            end
          endcase
        end
      end
      S_RD: begin
        ctl.addrSel = SEL_DATA;
        memReq      = 1'b1;
        if (memAck && memErr) begin
          ctl.setErr  = 1'b1;
          ctl.errCode = PH_XFER;
          nextState   = S_IDLE;
        end else if (memAck) begin
          ctl.captureMem = 1'b1;
          nextState      = S_PUSH;
        end
      end
      S_PUSH: begin
        ctl.addrSel = SEL_DATA;
        txValid     = 1'b1;
        if (txReady) begin
          ctl.wordDone = 1'b1;
          nextState    = flags.lastWord ? S_FIN : S_RD;
        end
      end
      S_POP: begin
        ctl.addrSel = SEL_DATA;
        rxReady     = 1'b1;
        if (rxValid) begin
          ctl.captureRx = 1'b1;
          nextState     = S_WR;
        end
      end
      S_WR: begin
        ctl.addrSel = SEL_DATA;
        memReq      = 1'b1;
        memWe       = 1'b1;
        if (memAck && memErr) begin
          ctl.setErr  = 1'b1;
          ctl.errCode = PH_XFER;
          nextState   = S_IDLE;
        end else if (memAck) begin
          ctl.wordDone = 1'b1;
          nextState    = flags.lastWord ? S_FIN : S_POP;
        end
      end
      S_FIN: begin
        ctl.setDescIrq = flags.intFlag;
        if (flags.endFlag) begin
          ctl.setDone = 1'b1;
          nextState   = S_IDLE;
        end else begin
          nextState = S_FETCH0;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (memReq && !memAck) |=> memReq);

  assert_tx_held_R4: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (txValid && !txReady) |=> txValid);

  assert_one_stream_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(txValid && rxReady));

  assert_err_halts_R11: assert property (@(posedge clk) disable iff (!rstN || softRst)
    ctl.setErr |=> idle);

  assert_write_dir_R13: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> flags.dirToMem);

  assert_soft_reset_stops_R14: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!memReq && !txValid && !rxReady));

endmodule

// File: rtl/sg_desc_dma.sv
module sg_desc_dma
  import sg_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dmaEn,
  input  logic        dirToMem,
  input  logic        softRst,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irq,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWrData,
  input  logic        memAck,
  input  logic        memErr,
  input  logic [31:0] memRdData,
  output logic        txValid,
  output logic [31:0] txData,
  input  logic        txReady,
  input  logic        rxValid,
  input  logic [31:0] rxData,
  output logic        rxReady
);

  ctlT  ctl;
  flagT flags;
  logic idle;

  sg_dma_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .softRst (softRst),
    .dmaEn   (dmaEn),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .flags   (flags),
    .memAck  (memAck),
    .memErr  (memErr),
    .txReady (txReady),
    .rxValid (rxValid),
    .ctl     (ctl),
    .memReq  (memReq),
    .memWe   (memWe),
    .txValid (txValid),
    .rxReady (rxReady),
    .idle    (idle)
  );

  sg_dma_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .dirToMem  (dirToMem),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .ctl       (ctl),
    .idle      (idle),
    .memRdData (memRdData),
    .rxData    (rxData),
    .flags     (flags),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .txData    (txData),
    .irq       (irq)
  );

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rstN || softRst)
    (memReq && !memAck) |=> $stable(memAddr) && $stable(memWe));

endmodule

// File: tb/tb_sg_desc_dma.sv
module tb_sg_desc_dma;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dmaEn = 1'b0;
  logic        dirToMem = 1'b0;
  logic        softRst = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWrData;
  logic        memAck = 1'b0;
  logic        memErr = 1'b0;
  logic [31:0] memRdData = '0;
  logic        txValid;
  logic [31:0] txData;
  logic        txReady = 1'b1;
  logic        rxValid = 1'b1;
  logic [31:0] rxData;
  logic        rxReady;

  int checks = 0;
  int errors = 0;

  logic [31:0] descMem [0:255];
  logic [31:0] wMem    [0:255];
  logic [31:0] txLog   [0:63];
  int          txCount = 0;
  logic [31:0] txLast  = '0;
  int          reqCount = 0;
  logic [31:0] firstReq = '0;
  logic [31:0] rxCnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sg_desc_dma dut (.*);

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'hA5C3_0000;
  endfunction

  assign rxData = 32'hC0DE_0000 + rxCnt;

  // Memory model: one-cycle acknowledge, error above 0x00F0_0000
  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
      memErr <= 1'b0;
    end else if (memReq && !memAck) begin
      memAck <= 1'b1;
      memErr <= memAddr >= 32'h00F0_0000;
      if (reqCount == 0) firstReq <= memAddr;
      reqCount <= reqCount + 1;
      if (memWe) begin
        if (memAddr >= 32'h800 && memAddr < 32'hC00) wMem[memAddr[9:2]] <= memWrData;
      end else if (memAddr < 32'h400) begin
        memRdData <= descMem[memAddr[9:2]];
      end else begin
        memRdData <= pat(memAddr);
      end
    end else begin
      memAck <= 1'b0;
      memErr <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (txValid && txReady) begin
      if (txCount < 64) txLog[txCount] <= txData;
      txLast  <= txData;
      txCount <= txCount + 1;
    end
    if (rxValid && rxReady) rxCnt <= rxCnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic putDesc(input logic [31:0] at, input logic [7:0] attr,
                         input logic [15:0] len, input logic [31:0] addr);
    descMem[at[9:2]]       = {len, 8'h00, attr};
    descMem[at[9:2] + 8'd1] = addr;
  endtask

  task automatic runChain(input logic [31:0] base, input bit dir);
    logic [31:0] st;
    regWrite(2'd1, 32'hFFFF_FFFF);
    @(negedge clk);
    txCount = 0; reqCount = 0; rxCnt = 0;
    dirToMem = dir;
    regWrite(2'd0, base);
    for (int i = 0; i < 100000; i++) begin
      regRead(2'd1, st);
      if (st[1] || st[25]) break;
    end
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(2'd1, v); check(v == 0, "R1 status", v, 0);
    regRead(2'd3, v); check(v == 0, "R1 errcode", v, 0);
    regRead(2'd2, v); check(v == 0, "R1 enable", v, 0);
    check(!irq && !memReq && !txValid, "R1 outputs idle", {29'd0, irq, memReq, txValid}, 0);
  endtask

  task automatic testNoStart();
    logic [31:0] v;
    dmaEn = 1'b0;
    reqCount = 0;
    regWrite(2'd0, 32'h100);
    repeat (10) @(negedge clk);
    check(reqCount == 0, "R2 no fetch without enable", reqCount, 0);
    regRead(2'd0, v); check(v == 32'h100, "R2 address loaded", v, 32'h100);
    dmaEn = 1'b1;
  endtask

  task automatic testMemToCard();
    logic [31:0] v, e;
    putDesc(32'h100, 8'h25, 16'd16, 32'h2000);
    putDesc(32'h108, 8'h23, 16'd8,  32'h3000);
    runChain(32'h100, 1'b0);
    check(firstReq == 32'h100, "R2 first fetch address", firstReq, 32'h100);
    check(txCount == 6, "R4 word count", txCount, 6);
    for (int i = 0; i < 6; i++) begin
      e = (i < 4) ? pat(32'h2000 + 4*i) : pat(32'h3000 + 4*(i-4));
      check(txLog[i] == e, "R3 R4 tx word order", txLog[i], e);
    end
    regRead(2'd1, v);
    check(v[1] && !v[25], "R6 done flag", v, 32'h2);
    check(v[3], "R12 descriptor interrupt flag", v, 32'h8);
    regRead(2'd0, v); check(v == 32'h110, "R6 pointer after end", v, 32'h110);
  endtask

  task automatic testCardToMem();
    logic [31:0] v;
    putDesc(32'h100, 8'h23, 16'd12, 32'h800);
    regWrite(2'd1, 32'hFFFF_FFFF);
    txCount = 0; rxCnt = 0;
    dirToMem = 1'b1;
    regWrite(2'd0, 32'h100);
    dirToMem = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      regRead(2'd1, v);
      if (v[1] || v[25]) break;
    end
    for (int i = 0; i < 3; i++)
      check(wMem[i] == 32'hC0DE_0000 + i, "R4 R13 rx word written", wMem[i], 32'hC0DE_0000 + i);
    check(txCount == 0, "R13 no tx after direction flip", txCount, 0);
    regRead(2'd1, v); check(!v[3], "R12 no flag without attribute", v, 0);
  endtask

  task automatic testLinkNop();
    logic [31:0] v;
    putDesc(32'h100, 8'h31, 16'd0, 32'h200);
    putDesc(32'h200, 8'h01, 16'd0, 32'h0);
    putDesc(32'h208, 8'h23, 16'd4, 32'h2400);
    runChain(32'h100, 1'b0);
    check(txCount == 1 && txLog[0] == pat(32'h2400), "R5 link and no-op", txLog[0], pat(32'h2400));
    regRead(2'd0, v); check(v == 32'h210, "R5 pointer in linked table", v, 32'h210);
  endtask

  task automatic expectErr(input string req, input logic [1:0] code, input logic [31:0] ptr);
    logic [31:0] v;
    regRead(2'd1, v); check(v[25] && !v[1], req, v, 32'h0200_0000);
    regRead(2'd3, v); check(v == {30'd0, code}, req, v, {30'd0, code});
    regRead(2'd0, v); check(v == ptr, req, v, ptr);
  endtask

  task automatic testInvalid();
    putDesc(32'h100, 8'h21, 16'd4, 32'h2000);
    putDesc(32'h108, 8'h20, 16'd4, 32'h2000);
    runChain(32'h100, 1'b0);
    expectErr("R8 invalid descriptor", 2'd1, 32'h108);
    check(txCount == 1, "R8 first segment moved", txCount, 1);
    check(!irq, "R11 irq masked", irq, 0);
    regWrite(2'd2, 32'h0200_0000);
    check(irq, "R11 irq enabled", irq, 1);
    regWrite(2'd1, 32'h0200_0000);
    check(!irq, "R11 irq cleared", irq, 0);
    regWrite(2'd2, 32'h0);
  endtask

  task automatic testReserved();
    putDesc(32'h100, 8'h11, 16'd4, 32'h2000);
    runChain(32'h100, 1'b0);
    expectErr("R10 reserved action", 2'd0, 32'h108);
  endtask

  task automatic testXferErrors();
    putDesc(32'h100, 8'h21, 16'd6, 32'h2000);
    runChain(32'h100, 1'b0);
    expectErr("R9 odd length", 2'd3, 32'h108);
    check(txCount == 0, "R9 nothing moved", txCount, 0);
    putDesc(32'h100, 8'h00, 16'd0, 32'h0);
    runChain(32'h100, 1'b0);
    putDesc(32'h100, 8'h21, 16'd8, 32'h2002);
    runChain(32'h100, 1'b0);
    expectErr("R9 misaligned buffer", 2'd3, 32'h108);
    putDesc(32'h100, 8'h00, 16'd0, 32'h0);
    runChain(32'h100, 1'b0);
    putDesc(32'h100, 8'h21, 16'd8, 32'h00F0_0000);
    runChain(32'h100, 1'b0);
    expectErr("R9 bus error in data", 2'd3, 32'h108);
  endtask

  task automatic testFetchBusErr();
    runChain(32'h00F0_0000, 1'b0);
    expectErr("R8 bus error in fetch", 2'd1, 32'h00F0_0000);
    runChain(32'h104, 1'b0);
    expectErr("R8 misaligned table", 2'd1, 32'h104);
  endtask

  task automatic testZeroLen();
    putDesc(32'h100, 8'h23, 16'd0, 32'h10000);
    runChain(32'h100, 1'b0);
    check(txCount == 16384, "R7 zero length moves 64 KiB", txCount, 16384);
    check(txLast == pat(32'h1FFFC), "R7 last word", txLast, pat(32'h1FFFC));
  endtask

  task automatic testSoftReset();
    int tc, rc;
    logic [31:0] v;
    putDesc(32'h100, 8'h23, 16'd0, 32'h10000);
    regWrite(2'd1, 32'hFFFF_FFFF);
    txCount = 0;
    dirToMem = 1'b0;
    regWrite(2'd0, 32'h100);
    repeat (200) @(negedge clk);
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    repeat (3) @(negedge clk);
    tc = txCount; rc = reqCount;
    repeat (50) @(negedge clk);
    check(txCount == tc && reqCount == rc && !memReq, "R14 activity ceased", txCount, tc);
    putDesc(32'h180, 8'h23, 16'd4, 32'h2400);
    runChain(32'h180, 1'b0);
    regRead(2'd1, v);
    check(v[1] && txLog[0] == pat(32'h2400), "R14 restart after soft reset", v, 32'h2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin descMem[i] = '0; wMem[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNoStart();
    testMemToCard();
    testCardToMem();
    testLinkNop();
    testInvalid();
    testReserved();
    testXferErrors();
    testFetchBusErr();
    testZeroLen();
    testSoftReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule